// File: doc/BRIEF.md
# Bidirectional Gate-Scan Shift Driver

This block makes the row-select pulses for the gate lines of an active-matrix display. A one-clock start pulse is captured on a rising clock edge and then walks down a chain of stages, so that exactly one output line is high for each clock. When the walk reaches the far end, the block emits a cascade pulse that starts the next driver in a chain of drivers.

The walk runs in either direction, set by `dir_fwd`. Each end of the chain has a start input and a cascade output, and only the pair that suits the chosen direction is active. A static strap, `short_mode`, sets the active length to 154 stages or to 150 stages. In the 150-stage mode, four lines in the middle of the array are held low and the chain jumps over them. Three enable-group inputs blank interleaved subsets of the lines without touching the chain. They act combinationally and do not wait for the clock.

Top module: `gate_scan_driver`

## Requirements
- R1: A start pulse that is high at a rising `clk` edge is loaded into the first stage of the active direction on that edge. The pulse then moves one stage for each later rising edge, so that `lines` changes only after rising edges.
- R2: With `dir_fwd`=1, the scan takes its start from `start_a_in` and runs from `lines[0]` up to `lines[153]`, and the cascade leaves on `casc_b_out`. With `dir_fwd`=0, the scan takes its start from `start_b_in` and runs from `lines[153]` down to `lines[0]`, and the cascade leaves on `casc_a_out`. The cascade output of the unused direction stays low.
- R3: With `short_mode`=1, bits `lines[78:75]` (lines 76 to 79) stay low at all times, and the chain passes straight between `lines[74]` and `lines[79]`. Across both directions this gives 150 active stages. With `short_mode`=0, all 154 stages are active.
- R4: The active cascade output rises on the falling edge that follows the Nth rising edge, counted from the capture edge as edge 1, and it falls on the next falling edge. N is 154 when `short_mode`=0 and 150 when `short_mode`=1.
- R5: Bit g-1 of `blank` controls enable group g. While that bit is 1, every line in group g is forced low, with no dependence on the clock. With `short_mode`=0, line n (bit n-1) belongs to group ((n-1) mod 3)+1.
- R6: With `short_mode`=1, lines 1 to 75 keep the grouping of R5. From line 80 upward, line n belongs to group ((n-5) mod 3)+1.
- R7: Blanking does not change the stage contents. When a blank input is released, the scan appears on the line it would have reached had no blanking taken place.
- R8: While `rst_n` is low at a rising edge, every stage is cleared. On the next falling edge the cascade register is cleared too, so all of `lines` and both cascade outputs read low.
- R9: A start pulse that is captured while an earlier pulse is still in the chain enters the first stage as normal. Each pulse then travels on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; the stages load on the rising edge, the cascade on the falling edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_fwd | input | 1 | 1 = scan from line 1 to line 154, 0 = scan the other way |
| short_mode | input | 1 | Static strap: 1 = 150 active stages, 0 = 154 active stages |
| blank | input | 3 | Enable-group blanking; bit g-1 forces group g low |
| start_a_in | input | 1 | Start pulse at the line-1 end, used when `dir_fwd`=1 |
| start_b_in | input | 1 | Start pulse at the line-154 end, used when `dir_fwd`=0 |
| casc_a_out | output | 1 | Cascade pulse at the line-1 end, active when `dir_fwd`=0 |
| casc_b_out | output | 1 | Cascade pulse at the line-154 end, active when `dir_fwd`=1 |
| lines | output | 154 | Gate-line outputs; bit n-1 drives line n |

## Verification
Blanking and shifting can fall in the same cycle: a line can be forced low in exactly the cycle in which the pulse arrives there or moves on. The bench redraws `blank` from a fixed-seed random source after every falling edge, often raising all groups or a single group for one or more cycles. After each rising edge it compares the whole `lines` vector with a bench-computed vector. That vector is the one expected pulse line, cleared if that line's group is blanked. A design that drops or stalls the pulse while blanked, or that blanks the wrong group, then shows a mismatch in the same cycle or in the next one.

// File: rtl/gate_scan_driver.sv
module gate_scan_driver #(
  parameter int NLINES     = 154,
  parameter int SKIP_FIRST = 76,
  parameter int SKIP_COUNT = 4,
  parameter int NGROUPS    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_fwd,
  input  logic              short_mode,
  input  logic [NGROUPS-1:0] blank,
  input  logic              start_a_in,
  input  logic              start_b_in,
  output logic              casc_a_out,
  output logic              casc_b_out,
  output logic [NLINES-1:0] lines
);
  localparam int SKIP_LO = SKIP_FIRST - 1;
  localparam int SKIP_HI = SKIP_LO + SKIP_COUNT - 1;
  localparam int BEFORE  = SKIP_LO - 1;
  localparam int RESUME  = SKIP_HI + 1;

  logic [NLINES-1:0] stage, nxt;
  logic casc_q;

  for (genvar i = 0; i < NLINES; i++) begin : g_stage
    localparam int GL = i % NGROUPS;
    localparam int GS = (i >= RESUME) ? ((i - SKIP_COUNT) % NGROUPS) : (i % NGROUPS);
    localparam bit IN_SKIP = (i >= SKIP_LO) && (i <= SKIP_HI);
    logic fwd_src, rev_src, skipped, gated;

    if (i == 0) begin : g_f0
      assign fwd_src = start_a_in;
    end else if (i == RESUME) begin : g_fr
      assign fwd_src = short_mode ? stage[BEFORE] : stage[i-1];
    end else begin : g_fn
      assign fwd_src = stage[i-1];
    end

    if (i == NLINES - 1) begin : g_r0
      assign rev_src = start_b_in;
    end else if (i == BEFORE) begin : g_rr
      assign rev_src = short_mode ? stage[RESUME] : stage[i+1];
    end else begin : g_rn
      assign rev_src = stage[i+1];
    end

    assign skipped  = short_mode & IN_SKIP;
    assign gated    = short_mode ? blank[GS] : blank[GL];
    assign nxt[i]   = skipped ? 1'b0 : (dir_fwd ? fwd_src : rev_src);
    assign lines[i] = stage[i] & ~gated & ~skipped;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stage <= '0;
    else        stage <= nxt;
  end

  always_ff @(negedge clk) begin
    if (!rst_n) casc_q <= 1'b0;
    else        casc_q <= dir_fwd ? stage[NLINES-1] : stage[0];
  end

  assign casc_b_out = dir_fwd & casc_q;
  assign casc_a_out = ~dir_fwd & casc_q;
endmodule

module gate_scan_chk #(
  parameter int NLINES = 154
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dir_fwd,
  input logic              short_mode,
  input logic [2:0]        blank,
  input logic              start_a_in,
  input logic              start_b_in,
  input logic              casc_a_out,
  input logic              casc_b_out,
  input logic [NLINES-1:0] lines
);
  p_capture_fwd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_fwd && blank == 3'b000) |=> (!dir_fwd || blank != 3'b000 || lines[0] == $past(start_a_in)));

  p_capture_rev_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_fwd && blank == 3'b000) |=> (dir_fwd || blank != 3'b000 || lines[NLINES-1] == $past(start_b_in)));

  p_shift_fwd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_fwd && blank == 3'b000) |=> (!dir_fwd || blank != 3'b000 || lines[1] == $past(lines[0])));

  p_shift_rev_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_fwd && blank == 3'b000) |=> (dir_fwd || blank != 3'b000 || lines[NLINES-2] == $past(lines[NLINES-1])));

  p_unused_casc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dir_fwd ? (casc_a_out == 1'b0) : (casc_b_out == 1'b0));

  p_skip_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    short_mode |-> lines[78:75] == 4'b0000);

  p_blank_g1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    blank[0] |-> (lines[0] == 1'b0 && lines[3] == 1'b0));

  p_reset_clear_r8: assert property (@(posedge clk)
    !rst_n |=> lines == '0);
endmodule

bind gate_scan_driver gate_scan_chk #(.NLINES(NLINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .dir_fwd(dir_fwd), .short_mode(short_mode),
  .blank(blank), .start_a_in(start_a_in), .start_b_in(start_b_in),
  .casc_a_out(casc_a_out), .casc_b_out(casc_b_out), .lines(lines)
);

// File: tb/sim_gate_scan_driver.sv
`timescale 1ns/1ps
module sim_gate_scan_driver;
  localparam int NL = 154;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir_fwd = 1'b1;
  logic short_mode = 1'b0;
  logic [2:0] blank = 3'b000;
  logic start_a_in = 1'b0;
  logic start_b_in = 1'b0;
  logic casc_a_out, casc_b_out;
  logic [NL-1:0] lines;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  gate_scan_driver u0 (
    .clk(clk), .rst_n(rst_n), .dir_fwd(dir_fwd), .short_mode(short_mode),
    .blank(blank), .start_a_in(start_a_in), .start_b_in(start_b_in),
    .casc_a_out(casc_a_out), .casc_b_out(casc_b_out), .lines(lines)
  );

  always #10 clk = ~clk;

  function automatic int active_len(bit sh);
    return sh ? 150 : 154;
  endfunction

  // physical line (1-based) reached at logical step k
  function automatic int phys(int k, bit dir, bit sh);
    int n = active_len(sh);
    int l = dir ? k : n - k + 1;
    return (sh && l > 75) ? l + 4 : l;
  endfunction

  // group index 0..2 of physical line p
  function automatic int grp(int p, bit sh);
    int q = (sh && p >= 80) ? p - 4 : p;
    return (q - 1) % 3;
  endfunction

  task automatic chk_vec(string req, logic [NL-1:0] act, logic [NL-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_bit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); #2 rst_n = 1'b0; start_a_in = 0; start_b_in = 0; blank = 0;
    @(posedge clk); @(negedge clk); #3;
    chk_vec("R8 lines after reset", lines, '0);
    chk_bit("R8 casc_a after reset", casc_a_out, 1'b0);
    chk_bit("R8 casc_b after reset", casc_b_out, 1'b0);
    #0 rst_n = 1'b1;
  endtask

  task automatic scan(bit dir, bit sh, bit rnd_blank);
    int n = active_len(sh);
    logic [NL-1:0] exp;
    @(negedge clk); #2 dir_fwd = dir; short_mode = sh;
    do_reset();
    @(negedge clk); #2;
    if (dir) start_a_in = 1'b1; else start_b_in = 1'b1;
    blank = 3'b000;
    for (int k = 1; k <= n + 1; k++) begin
      @(posedge clk); #3;
      exp = '0;
      if (k <= n) begin
        int p = phys(k, dir, sh);
        if (!blank[grp(p, sh)]) exp[p-1] = 1'b1;
      end
      chk_vec("R1 R2 R5 R6 R7 scan line", lines, exp);
      if (sh) chk_vec("R3 skipped lines low", {{(NL-4){1'b0}}, lines[78:75]}, '0);
      @(negedge clk); #3;
      chk_bit("R4 cascade active pin", dir ? casc_b_out : casc_a_out, (k == n));
      chk_bit("R2 cascade unused pin", dir ? casc_a_out : casc_b_out, 1'b0);
      start_a_in = 1'b0; start_b_in = 1'b0;
      if (rnd_blank && ($urandom % 3 == 0)) blank = 3'($urandom % 8);
      else blank = 3'b000;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    do_reset();

    // directed: each direction and length, no blanking
    scan(1'b1, 1'b0, 1'b0);
    scan(1'b0, 1'b0, 1'b0);
    scan(1'b1, 1'b1, 1'b0);
    scan(1'b0, 1'b1, 1'b0);
    // random blanking on all four combinations
    for (int r = 0; r < 2; r++) begin
      scan(1'b1, 1'b0, 1'b1);
      scan(1'b0, 1'b0, 1'b1);
      scan(1'b1, 1'b1, 1'b1);
      scan(1'b0, 1'b1, 1'b1);
    end

    // R5 group mapping directly: fill the chain with all ones, then blank one group at a time
    @(negedge clk); #2 dir_fwd = 1; short_mode = 0;
    do_reset();
    @(negedge clk); #2 start_a_in = 1;
    for (int k = 0; k < NL; k++) @(posedge clk);
    @(negedge clk); #2 start_a_in = 0;
    for (int g = 0; g < 3; g++) begin
      logic [NL-1:0] exp = '0;
      #1 blank = 3'(1 << g);
      #1;
      for (int p = 1; p <= NL; p++) exp[p-1] = (p < NL) ? ((((p - 1) % 3) != g) ? 1'b1 : 1'b0) : 1'b0;
      // line NL held the start that was dropped at the previous posedge? chain is full here
      exp[NL-1] = (((NL - 1) % 3) != g);
      chk_vec("R5 async group blank", lines, exp);
    end
    #1 blank = 3'b000;

    // R9 overlapping pulses: captures at steps 1 and 4, check after step 6
    @(negedge clk); #2 dir_fwd = 1; short_mode = 0;
    do_reset();
    @(negedge clk); #2 start_a_in = 1;
    @(negedge clk); #2 start_a_in = 0;
    @(negedge clk);
    @(negedge clk); #2 start_a_in = 1;
    @(negedge clk); #2 start_a_in = 0;
    @(posedge clk); @(posedge clk); #3;
    begin
      logic [NL-1:0] exp = '0;
      exp[5] = 1'b1; exp[2] = 1'b1;
      chk_vec("R9 two pulses in flight", lines, exp);
    end

    // R8 reset in the middle of a scan
    do_reset();
    chk_vec("R8 mid-scan reset clears chain", lines, '0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule